// File: doc/BRIEF.md
# Frequency-Locked Loop Controller

This block is the digital loop that holds a digitally controlled oscillator at a programmable multiple of a slow reference clock. It runs on the oscillator's own output clock. The reference is brought into that domain through a synchroniser. The block counts oscillator cycles between successive reference rising edges and compares the count with the target N+1. At each boundary it moves a tap code one step toward the target. When no tap gives the exact ratio, the code alternates between the two neighbouring taps, and the long-term average frequency then meets the goal.

After a power-up clear the tap code is at its slowest setting and the multiplier is 32. Correction starts as soon as reset is released, provided the crystal reports stable. A lock flag reports that several periods in a row landed within one cycle of the target. A single-cycle write port loads a new N, which takes effect at the next reference boundary.

Top module: `fll_ctrl`

## Requirements
- R1: While rst_n is low at a dco_clk edge, tap_code becomes 0 (slowest), locked becomes 0, N becomes 31 and the target count becomes 32.
- R2: The first synchronised reference rising edge after reset only starts measurement. It never changes tap_code.
- R3: The measured count is the number of dco_clk cycles between two synchronised reference rising edges. A count above N+1 lowers tap_code by one, a count below N+1 raises it by one, and a count equal to N+1 leaves it unchanged.
- R4: tap_code saturates: it stays at 0 when asked to go lower, and at 2^TAP_W-1 (31 by default) when asked to go higher.
- R5: When xtal_ok is low at a boundary, tap_code is held and the lock run is restarted.
- R6: locked goes high after 4 consecutive qualified boundaries whose count is within N+1±1. A boundary outside the window clears it.
- R7: A write (n_wr_en high for one cycle) clears locked after the next dco_clk edge. The new N is loaded at the following reference boundary, and the period ending at that boundary is still judged against the old N.
- R8: The period counter saturates at 2^CNT_W-1 (1023 by default) and does not wrap, so an overlong period still reads as too slow.
- R9: tap_code changes only on a boundary with xtal_ok high, and by at most one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dco_clk | input | 1 | Oscillator output clock; all logic runs on it |
| rst_n | input | 1 | Synchronous active-low power-up clear |
| ref_clk | input | 1 | Slow reference (crystal) clock, asynchronous |
| xtal_ok | input | 1 | High when the reference oscillator is stable |
| n_wr_en | input | 1 | One-cycle strobe that writes a new multiplier N |
| n_wr_data | input | N_W | New value of N |
| tap_code | output | TAP_W | Oscillator tap code, 0 is slowest |
| locked | output | 1 | Loop has held the target for the required run |

## Verification
The hardest case to reach is the rising edge of the period counter's saturation. A wrapping counter would report a short period instead of a long one, and with the code already at its top tap the two results look alike. The stimulus first drives the code to its maximum with short periods. It then applies one period of 1030 cycles and checks that the code steps down, where a wrapped count would have held it at the top. A similar ordering problem exists for the multiplier write. The bench measures exactly one period across the write so that the old target still applies to it, and only the next period sees the new one.

// File: rtl/fll_pkg.sv
// Shared types for the frequency-locked loop controller.
package fll_pkg;
    // Direction chosen for the tap code at a reference boundary.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/fll_edge_sync.sv
// Brings an asynchronous slow clock into the local domain through a
// flop chain and flags its rising edge for one local cycle.
// Assumes the input stays high and low for at least two local cycles each.
module fll_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    // Synchroniser chain; stage 0 takes the asynchronous input.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Delayed copy of the synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/fll_period_counter.sv
// Counts local cycles since the last restart, holding at the top value.
// On restart the current cycle counts as the first of the new period, so
// the value seen in the restart cycle equals the length of the period.
module fll_period_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Saturating cycle count, restarted at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (restart)          count <= CNT_W'(1);
        else if (count != CNT_MAX) count <= count + 1'b1;
    end
endmodule

// File: rtl/fll_tap_ctrl.sv
// Compares each period's cycle count with N+1, steps the tap code one
// place toward the target, tracks lock, and holds the multiplier register
// with its deferred load. Assumes count is valid in the cycle of ref_rise.
module fll_tap_ctrl
    import fll_pkg::*;
#(
    parameter int TAP_W     = 5,
    parameter int N_W       = 8,
    parameter int CNT_W     = 10,
    parameter int LOCK_RUNS = 4,
    parameter int N_RESET   = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_rise,
    input  logic             xtal_ok,
    input  logic [CNT_W-1:0] count,
    input  logic             n_wr_en,
    input  logic [N_W-1:0]   n_wr_data,
    output logic [TAP_W-1:0] tap_code,
    output logic             locked
);
    localparam int              CMP_W   = ((CNT_W > N_W) ? CNT_W : N_W) + 2;
    localparam int              RUN_W   = $clog2(LOCK_RUNS + 1);
    localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

    logic             primed;
    logic [N_W-1:0]   n_cur;
    logic [N_W-1:0]   n_pend;
    logic             pend_valid;
    logic [RUN_W-1:0] run_len;
    logic [CMP_W-1:0] meas;
    logic [CMP_W-1:0] tgt;
    logic             near;
    logic             judge;
    step_e            step;

    // Decide the step direction and the lock window for this period.
    always_comb begin
        meas = CMP_W'(count);
        tgt  = CMP_W'(n_cur) + CMP_W'(1);
        if (meas > tgt)      step = STEP_DOWN;
        else if (meas < tgt) step = STEP_UP;
        else                 step = STEP_HOLD;
        near  = (meas + CMP_W'(1) >= tgt) && (meas <= tgt + CMP_W'(1));
        judge = ref_rise && primed;
    end

    // Mark that one boundary has been seen, so later counts are whole periods.
    always_ff @(posedge clk) begin
        if (!rst_n)        primed <= 1'b0;
        else if (ref_rise) primed <= 1'b1;
    end

    // Multiplier register: a write waits for the next boundary to load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_cur      <= N_W'(N_RESET);
            n_pend     <= '0;
            pend_valid <= 1'b0;
        end else begin
            if (ref_rise && pend_valid) begin
                n_cur      <= n_pend;
                pend_valid <= 1'b0;
            end
            if (n_wr_en) begin
                n_pend     <= n_wr_data;
                pend_valid <= 1'b1;
            end
        end
    end

    // Tap code: one saturating step per qualified boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_code <= '0;
        end else if (judge && xtal_ok) begin
            case (step)
                STEP_UP:   if (tap_code != TAP_MAX) tap_code <= tap_code + 1'b1;
                STEP_DOWN: if (tap_code != '0)      tap_code <= tap_code - 1'b1;
                default:   tap_code <= tap_code;
            endcase
        end
    end

    // Lock run length: counts consecutive in-window boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n)                           run_len <= '0;
        else if (n_wr_en)                     run_len <= '0;
        else if (judge && !(xtal_ok && near)) run_len <= '0;
        else if (judge && run_len != RUN_W'(LOCK_RUNS))
            run_len <= run_len + 1'b1;
    end

    assign locked = (run_len == RUN_W'(LOCK_RUNS));
endmodule

// File: rtl/fll_ctrl.sv
// Top of the frequency-locked loop controller. Runs on the oscillator
// clock, synchronises the reference, measures each reference period and
// drives the tap code. Assumes the reference is much slower than dco_clk.
module fll_ctrl #(
    parameter int TAP_W     = 5,
    parameter int N_W       = 8,
    parameter int CNT_W     = 10,
    parameter int SYNC_LEN  = 2,
    parameter int LOCK_RUNS = 4,
    parameter int N_RESET   = 31
) (
    input  logic             dco_clk,
    input  logic             rst_n,
    input  logic             ref_clk,
    input  logic             xtal_ok,
    input  logic             n_wr_en,
    input  logic [N_W-1:0]   n_wr_data,
    output logic [TAP_W-1:0] tap_code,
    output logic             locked
);
    logic             ref_rise;
    logic [CNT_W-1:0] count;

    fll_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk      (dco_clk),
        .rst_n    (rst_n),
        .async_in (ref_clk),
        .rise     (ref_rise)
    );

    fll_period_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (dco_clk),
        .rst_n   (rst_n),
        .restart (ref_rise),
        .count   (count)
    );

    fll_tap_ctrl #(
        .TAP_W     (TAP_W),
        .N_W       (N_W),
        .CNT_W     (CNT_W),
        .LOCK_RUNS (LOCK_RUNS),
        .N_RESET   (N_RESET)
    ) u_tap (
        .clk       (dco_clk),
        .rst_n     (rst_n),
        .ref_rise  (ref_rise),
        .xtal_ok   (xtal_ok),
        .count     (count),
        .n_wr_en   (n_wr_en),
        .n_wr_data (n_wr_data),
        .tap_code  (tap_code),
        .locked    (locked)
    );
endmodule

// File: rtl/fll_ctrl_checker.sv
// Temporal checks on the loop controller, attached by bind below.
// Assumes ref_rise is the synchroniser's one-cycle boundary strobe.
module fll_ctrl_checker #(
    parameter int TAP_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_rise,
    input logic             xtal_ok,
    input logic             n_wr_en,
    input logic [TAP_W-1:0] tap_code,
    input logic             locked
);
    // R1: a clear cycle leaves the slowest tap and no lock.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (tap_code == '0) && !locked);

    // R9: no movement outside a qualified boundary.
    assert_tap_only_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_rise && xtal_ok) |=> $stable(tap_code));

    // R9: at most one step per boundary.
    assert_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tap_code == $past(tap_code)) ||
                 (tap_code == $past(tap_code) + 1'b1) ||
                 (tap_code == $past(tap_code) - 1'b1));

    // R5: an unstable crystal at a boundary holds the code.
    assert_hold_unstable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rise && !xtal_ok) |=> $stable(tap_code));

    // R7: a multiplier write drops lock.
    assert_write_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        n_wr_en |=> !locked);

    // R6: lock is only gained at a boundary.
    assert_lock_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(ref_rise));
endmodule

bind fll_ctrl fll_ctrl_checker #(.TAP_W(TAP_W)) u_chk (
    .clk      (dco_clk),
    .rst_n    (rst_n),
    .ref_rise (ref_rise),
    .xtal_ok  (xtal_ok),
    .n_wr_en  (n_wr_en),
    .tap_code (tap_code),
    .locked   (locked)
);

// File: tb/fll_ctrl_test.sv
// Self-checking bench: a vector table of reference periods, then directed
// tests for multiplier writes, saturation and mid-run reset.
module fll_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_clk = 1'b0;
    logic       xtal_ok = 1'b0;
    logic       n_wr_en = 1'b0;
    logic [7:0] n_wr_data = '0;
    logic [4:0] tap_code;
    logic       locked;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    fll_ctrl uut (
        .dco_clk   (clk),
        .rst_n     (rst_n),
        .ref_clk   (ref_clk),
        .xtal_ok   (xtal_ok),
        .n_wr_en   (n_wr_en),
        .n_wr_data (n_wr_data),
        .tap_code  (tap_code),
        .locked    (locked)
    );

    // Each entry: crystal state for the boundary that starts this span,
    // span length in dco cycles, tap and lock expected after that boundary.
    typedef struct packed {
        logic        xtal;
        int          len;
        int          tap;
        logic        lk;
    } vec_t;

    localparam vec_t VECS [15] = '{
        '{1'b1, 40, 0, 1'b0},   // R2 priming boundary
        '{1'b1, 40, 0, 1'b0},   // R4 count 40 > 32 at tap 0
        '{1'b1, 20, 0, 1'b0},   // R4 again at floor
        '{1'b1, 20, 1, 1'b0},   // R3 count 20 < 32
        '{1'b1, 33, 2, 1'b0},   // R3 count 20
        '{1'b1, 31, 1, 1'b0},   // R3 count 33, run 1
        '{1'b1, 32, 2, 1'b0},   // R3 count 31 (alternation), run 2
        '{1'b1, 32, 2, 1'b0},   // R3 count 32 hold, run 3
        '{1'b1, 40, 2, 1'b1},   // R6 run 4 -> locked
        '{1'b0, 20, 2, 1'b0},   // R5 count 40 but crystal unstable
        '{1'b1, 33, 3, 1'b0},   // R3 count 20
        '{1'b1, 32, 2, 1'b0},   // R6 run 1
        '{1'b1, 32, 2, 1'b0},   // R6 run 2
        '{1'b1, 32, 2, 1'b0},   // R6 run 3
        '{1'b1, 32, 2, 1'b1}    // R6 run 4 -> locked
    };

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One reference period of len dco cycles, starting with a rising edge.
    task automatic span(input int len, input logic x);
        @(negedge clk);
        ref_clk = 1'b1;
        xtal_ok = x;
        repeat (len / 2) @(negedge clk);
        ref_clk = 1'b0;
        repeat (len - len / 2 - 1) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 tap after reset", int'(tap_code), 0);
        check("R1 lock after reset", int'(locked), 0);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < 15; i++) begin
            span(VECS[i].len, VECS[i].xtal);
            check($sformatf("R3 table tap entry %0d", i), int'(tap_code), VECS[i].tap);
            check($sformatf("R6 table lock entry %0d", i), int'(locked), int'(VECS[i].lk));
        end

        // R7: write N=15 while locked; period around the write is 32 cycles
        span(31, 1'b1);
        n_wr_data = 8'd15;
        n_wr_en   = 1'b1;
        @(negedge clk);
        n_wr_en   = 1'b0;
        check("R7 lock cleared by write", int'(locked), 0);
        span(32, 1'b1);     // judged against old target 32: hold
        check("R7 old target at load boundary", int'(tap_code), 2);
        check("R7 lock stays low", int'(locked), 0);
        span(8, 1'b1);      // count 32 vs new target 16: down
        check("R7 new target applied", int'(tap_code), 1);

        // R4: drive to top tap with short periods
        for (int k = 0; k < 32; k++) span(8, 1'b1);
        check("R4 tap saturates at top", int'(tap_code), 31);

        // R8: overlong period must read as slow, not wrap to a short count
        span(1030, 1'b1);
        span(8, 1'b1);
        check("R8 saturated count steps down", int'(tap_code), 30);

        // R1: mid-run reset restores tap, lock and N=31
        @(negedge clk);
        rst_n   = 1'b0;
        ref_clk = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 tap after mid-run reset", int'(tap_code), 0);
        check("R1 lock after mid-run reset", int'(locked), 0);
        rst_n = 1'b1;
        span(20, 1'b1);
        check("R2 first boundary only primes", int'(tap_code), 0);
        span(20, 1'b1);     // count 20 < 32 -> up (would drop with N=15)
        check("R1 default multiplier restored", int'(tap_code), 1);

        done = 1'b1;
        finish_run();
    end
endmodule